// File: doc/BRIEF.md
# Dual-Channel Test Pattern Generator

This block sits in the sample path of a two-channel converter. It can replace the live sample stream of either channel with a known pattern, so that the capture logic further down can be checked without an analog signal. Each channel has its own 3-bit mode code. One code passes the live data through. One code emits a counter that grows by a programmable step on every accepted sample. One code emits a fixed word.

Both channels share a single 18-bit pattern word. The word is written as three slices: a 2-bit top slice, a middle byte and a low byte. In ramp mode the word is the step size. In constant mode it is the value to emit, placed against the MSB of the output sample. Every output is registered, so each channel has one cycle of latency. Output valid repeats input valid. After reset both channels pass their live data through.

Top module: `tpg_dual`

## Requirements
- R1: While reset is high, and on the first cycle after it, both channels drive valid low and sample zero.
- R2: For each channel, the output valid in a cycle equals that channel's input valid one clock earlier.
- R3: With mode code 3'b000 and input valid high, the output sample one clock later equals the input sample.
- R4: Mode codes 3'b001, 3'b100, 3'b101, 3'b110 and 3'b111 act exactly like 3'b000 (live pass-through).
- R5: With mode code 3'b011 and input valid high, the output sample one clock later equals the pattern word {top[1:0], middle[7:0], low[7:0]}, MSB aligned (with default widths, the word itself).
- R6: With mode code 3'b010, the first valid sample after the channel enters ramp mode outputs 0. Each later valid sample outputs the previous ramp value plus the pattern word that was present at the previous valid sample.
- R7: When input valid is low, the output sample holds its last value and the ramp does not advance.
- R8: Any cycle spent in a mode other than 3'b010 clears the ramp, so that re-entering ramp mode starts again from 0.
- R9: The two channels are independent: each has its own mode code and its own ramp state, and only the pattern word is shared.
- R10: The ramp value wraps modulo 2^18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch0_valid_i | input | 1 | Channel 0 live sample strobe |
| ch0_sample_i | input | 18 | Channel 0 live sample |
| ch0_mode_i | input | 3 | Channel 0 mode code |
| ch1_valid_i | input | 1 | Channel 1 live sample strobe |
| ch1_sample_i | input | 18 | Channel 1 live sample |
| ch1_mode_i | input | 3 | Channel 1 mode code |
| pat_lo_i | input | 8 | Pattern word bits 7:0 |
| pat_mid_i | input | 8 | Pattern word bits 15:8 |
| pat_top_i | input | 2 | Pattern word bits 17:16 |
| ch0_valid_o | output | 1 | Channel 0 output strobe |
| ch0_sample_o | output | 18 | Channel 0 output sample |
| ch1_valid_o | output | 1 | Channel 1 output strobe |
| ch1_sample_o | output | 18 | Channel 1 output sample |

## Verification
Directed cases run first. A pass-through case with distinct live values per channel separates pass-through from pattern output, and an unused code is tried on one channel. A constant word with a different value in each slice exposes swapped or misplaced slices. A ramp with small steps and gaps in valid separates "advance per valid sample" from "advance per clock". A ramp with step 0x3FFFF is left and re-entered, which shows both the wrap and the restart from zero. After these, a long stretch of random cycles changes mode codes, valid and the pattern word on each channel separately. A reference model in the bench checks every output, so any state leaking from one channel to the other is caught.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TPG_PAT_W    = 18;
    localparam int TPG_SAMPLE_W = 18;
    localparam int TPG_MODE_W   = 3;

    localparam logic [TPG_MODE_W-1:0] TPG_CODE_PASS  = 3'b000;
    localparam logic [TPG_MODE_W-1:0] TPG_CODE_RAMP  = 3'b010;
    localparam logic [TPG_MODE_W-1:0] TPG_CODE_CONST = 3'b011;

    typedef enum logic [1:0] {
        TPG_SEL_PASS,
        TPG_SEL_RAMP,
        TPG_SEL_CONST
    } tpg_sel_e;

    // Codes without a defined meaning fall back to pass-through.
    function automatic tpg_sel_e tpg_decode(input logic [TPG_MODE_W-1:0] code);
        tpg_sel_e sel;
        case (code)
            TPG_CODE_RAMP:  sel = TPG_SEL_RAMP;
            TPG_CODE_CONST: sel = TPG_SEL_CONST;
            default:        sel = TPG_SEL_PASS;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/tpg_word_join.sv
module tpg_word_join #(
    parameter int PAT_W = tpg_pkg::TPG_PAT_W,
    localparam int TOP_W = PAT_W - 16
) (
    input  logic [7:0]       lo_i,
    input  logic [7:0]       mid_i,
    input  logic [TOP_W-1:0] top_i,
    output logic [PAT_W-1:0] word_o
);
    assign word_o = {top_i, mid_i, lo_i};
endmodule

// File: rtl/tpg_ramp.sv
module tpg_ramp #(
    parameter int PAT_W = tpg_pkg::TPG_PAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             adv_i,
    input  logic [PAT_W-1:0] step_i,
    output logic [PAT_W-1:0] value_o
);
    logic [PAT_W-1:0] cnt_q;

    // Counter is held at zero outside ramp mode; it wraps naturally at 2^PAT_W.
    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= cnt_q + step_i;
        end
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
    import tpg_pkg::*;
#(
    parameter int PAT_W    = TPG_PAT_W,
    parameter int SAMPLE_W = TPG_SAMPLE_W,
    localparam int SHIFT   = SAMPLE_W - PAT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  valid_i,
    input  logic [SAMPLE_W-1:0]   sample_i,
    input  logic [TPG_MODE_W-1:0] mode_i,
    input  logic [PAT_W-1:0]      word_i,
    output logic                  valid_o,
    output logic [SAMPLE_W-1:0]   sample_o
);
    tpg_sel_e            sel;
    logic [PAT_W-1:0]    ramp_val;
    logic [SAMPLE_W-1:0] pick;
    logic                valid_q;
    logic [SAMPLE_W-1:0] data_q;

    assign sel = tpg_decode(mode_i);

    tpg_ramp #(.PAT_W(PAT_W)) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .run_i   (sel == TPG_SEL_RAMP),
        .adv_i   (valid_i),
        .step_i  (word_i),
        .value_o (ramp_val)
    );

    always_comb begin
        case (sel)
            TPG_SEL_RAMP:  pick = SAMPLE_W'(ramp_val) << SHIFT;
            TPG_SEL_CONST: pick = SAMPLE_W'(word_i) << SHIFT;
            default:       pick = sample_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                data_q <= pick;
            end
        end
    end

    assign valid_o  = valid_q;
    assign sample_o = data_q;
endmodule

// File: rtl/tpg_dual.sv
module tpg_dual
    import tpg_pkg::*;
#(
    parameter int PAT_W    = TPG_PAT_W,
    parameter int SAMPLE_W = TPG_SAMPLE_W,
    localparam int TOP_W   = PAT_W - 16,
    localparam int NUM_CH  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ch0_valid_i,
    input  logic [SAMPLE_W-1:0]   ch0_sample_i,
    input  logic [TPG_MODE_W-1:0] ch0_mode_i,
    input  logic                  ch1_valid_i,
    input  logic [SAMPLE_W-1:0]   ch1_sample_i,
    input  logic [TPG_MODE_W-1:0] ch1_mode_i,
    input  logic [7:0]            pat_lo_i,
    input  logic [7:0]            pat_mid_i,
    input  logic [TOP_W-1:0]      pat_top_i,
    output logic                  ch0_valid_o,
    output logic [SAMPLE_W-1:0]   ch0_sample_o,
    output logic                  ch1_valid_o,
    output logic [SAMPLE_W-1:0]   ch1_sample_o
);
    logic [PAT_W-1:0]                   word;
    logic [NUM_CH-1:0]                  v_in;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]    s_in;
    logic [NUM_CH-1:0][TPG_MODE_W-1:0]  m_in;
    logic [NUM_CH-1:0]                  v_out;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]    s_out;

    tpg_word_join #(.PAT_W(PAT_W)) u_join (
        .lo_i   (pat_lo_i),
        .mid_i  (pat_mid_i),
        .top_i  (pat_top_i),
        .word_o (word)
    );

    assign v_in = {ch1_valid_i, ch0_valid_i};
    assign s_in = {ch1_sample_i, ch0_sample_i};
    assign m_in = {ch1_mode_i, ch0_mode_i};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tpg_channel #(.PAT_W(PAT_W), .SAMPLE_W(SAMPLE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .valid_i  (v_in[c]),
            .sample_i (s_in[c]),
            .mode_i   (m_in[c]),
            .word_i   (word),
            .valid_o  (v_out[c]),
            .sample_o (s_out[c])
        );
    end

    assign ch0_valid_o  = v_out[0];
    assign ch1_valid_o  = v_out[1];
    assign ch0_sample_o = s_out[0];
    assign ch1_sample_o = s_out[1];
endmodule

// File: rtl/tpg_dual_chk.sv
module tpg_dual_chk
    import tpg_pkg::*;
#(
    parameter int PAT_W    = TPG_PAT_W,
    parameter int SAMPLE_W = TPG_SAMPLE_W,
    localparam int SHIFT   = SAMPLE_W - PAT_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   valid_i,
    input logic [1:0][SAMPLE_W-1:0]     data_i,
    input logic [1:0][TPG_MODE_W-1:0]   mode_i,
    input logic [PAT_W-1:0]             word_i,
    input logic [1:0]                   valid_o,
    input logic [1:0][SAMPLE_W-1:0]     data_o
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R2
        valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd1) |-> (valid_o[c] == $past(valid_i[c])));

        // R3
        pass_data_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd1 && $past(valid_i[c]) &&
             tpg_decode($past(mode_i[c])) == TPG_SEL_PASS)
            |-> (data_o[c] == $past(data_i[c])));

        // R5
        const_data_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd1 && $past(valid_i[c]) && $past(mode_i[c]) == TPG_CODE_CONST)
            |-> (data_o[c] == (SAMPLE_W'($past(word_i)) << SHIFT)));

        // R6
        ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && $past(valid_i[c]) && $past(valid_i[c], 2) &&
             $past(mode_i[c]) == TPG_CODE_RAMP && $past(mode_i[c], 2) == TPG_CODE_RAMP)
            |-> (data_o[c] == $past(data_o[c]) + (SAMPLE_W'($past(word_i, 2)) << SHIFT)));

        // R8
        ramp_restart_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2 && $past(valid_i[c]) &&
             $past(mode_i[c]) == TPG_CODE_RAMP && $past(mode_i[c], 2) != TPG_CODE_RAMP)
            |-> (data_o[c] == '0));

        // R7
        hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd1 && !$past(valid_i[c])) |-> $stable(data_o[c]));
    end
endmodule

bind tpg_dual tpg_dual_chk #(.PAT_W(PAT_W), .SAMPLE_W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i ({ch1_valid_i, ch0_valid_i}),
    .data_i  ({ch1_sample_i, ch0_sample_i}),
    .mode_i  ({ch1_mode_i, ch0_mode_i}),
    .word_i  ({pat_top_i, pat_mid_i, pat_lo_i}),
    .valid_o ({ch1_valid_o, ch0_valid_o}),
    .data_o  ({ch1_sample_o, ch0_sample_o})
);

// File: tb/tpg_dual_bench.sv
module tpg_dual_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        v0 = 0, v1 = 0;
    logic [17:0] s0 = 0, s1 = 0;
    logic [2:0]  m0 = 0, m1 = 0;
    logic [7:0]  plo = 0, pmid = 0;
    logic [1:0]  ptop = 0;
    logic        ov0, ov1;
    logic [17:0] os0, os1;

    int n_run  = 0;
    int n_fail = 0;

    logic [17:0] mc [2];
    logic [17:0] ed [2];
    logic        ev [2];

    always #5 clk = ~clk;

    tpg_dual u_tpg_dual (
        .clk(clk), .rst(rst),
        .ch0_valid_i(v0), .ch0_sample_i(s0), .ch0_mode_i(m0),
        .ch1_valid_i(v1), .ch1_sample_i(s1), .ch1_mode_i(m1),
        .pat_lo_i(plo), .pat_mid_i(pmid), .pat_top_i(ptop),
        .ch0_valid_o(ov0), .ch0_sample_o(os0),
        .ch1_valid_o(ov1), .ch1_sample_o(os1)
    );

    function automatic logic [17:0] want(input logic [2:0] m, input logic [17:0] cnt,
                                         input logic [17:0] w, input logic [17:0] s);
        if (m == 3'b010) return cnt;
        if (m == 3'b011) return w;
        return s;
    endfunction

    function automatic string tag_of(input logic [2:0] m, input logic v);
        if (!v) return "R7";
        if (m == 3'b010) return "R6";
        if (m == 3'b011) return "R5";
        if (m == 3'b000) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
        end
    endtask

    // Inputs are already set; update model, wait one clock, compare.
    task automatic step();
        logic [17:0] w;
        logic [2:0]  m [2];
        logic        v [2];
        logic [17:0] s [2];
        string       t [2];
        w = {ptop, pmid, plo};
        m[0] = m0; m[1] = m1; v[0] = v0; v[1] = v1; s[0] = s0; s[1] = s1;
        for (int c = 0; c < 2; c++) begin
            t[c]  = tag_of(m[c], v[c]);
            ev[c] = v[c];
            if (v[c]) ed[c] = want(m[c], mc[c], w, s[c]);
            if (m[c] != 3'b010) mc[c] = '0;
            else if (v[c])      mc[c] = mc[c] + w;
        end
        @(negedge clk);
        check("R2", {17'd0, ov0}, {17'd0, ev[0]});
        check("R2", {17'd0, ov1}, {17'd0, ev[1]});
        check(t[0], os0, ed[0]);
        check(t[1], os1, ed[1]);
    endtask

    task automatic set_word(input logic [17:0] w);
        ptop = w[17:16]; pmid = w[15:8]; plo = w[7:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        mc[0] = 0; mc[1] = 0; ed[0] = 0; ed[1] = 0; ev[0] = 0; ev[1] = 0;
        void'($urandom(32'h5eed_7a11));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1", {17'd0, ov0}, 18'd0);
        check("R1", {17'd0, ov1}, 18'd0);
        check("R1", os0, 18'd0);
        check("R1", os1, 18'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {ov1, os1, ov0, os0} == '0 ? 18'd0 : 18'd1, 18'd0);

        // R3 / R4: pass-through with distinct data; ch1 uses unused code 101
        v0 = 1; v1 = 1; s0 = 18'h12345; s1 = 18'h2ABCD; m0 = 3'b000; m1 = 3'b101;
        set_word(18'h3FFFF);
        step();
        check("R3", os0, 18'h12345);
        check("R4", os1, 18'h2ABCD);

        // R5: constant with distinct slices
        set_word(18'h2C3A5); m0 = 3'b011; m1 = 3'b000;
        step();
        check("R5", os0, 18'h2C3A5);

        // R6 / R7 / R9: ch1 ramp step 5 with a gap, ch0 stays constant
        set_word(18'd5); m1 = 3'b010; v1 = 1;
        step(); check("R6", os1, 18'd0);
        step(); check("R6", os1, 18'd5);
        check("R9", os0, 18'd5);
        v1 = 0; s1 = 18'h11111;
        step(); check("R7", os1, 18'd5);
        check("R7", {17'd0, ov1}, 18'd0);
        v1 = 1;
        step(); check("R7", os1, 18'd10);

        // R8 / R10: leave ramp one cycle, re-enter with step 0x3FFFF
        m1 = 3'b000; s1 = 18'h00777;
        step(); check("R8", os1, 18'h00777);
        set_word(18'h3FFFF); m1 = 3'b010; m0 = 3'b010;
        step(); check("R8", os1, 18'd0);
        step(); check("R10", os1, 18'h3FFFF);
        step(); check("R10", os1, 18'h3FFFE);
        check("R9", os0, 18'h3FFFE);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(7) == 0) m0 = ($urandom_range(3) == 0) ? 3'($urandom) : 3'($urandom_range(3));
            if ($urandom_range(7) == 0) m1 = ($urandom_range(3) == 0) ? 3'($urandom) : 3'($urandom_range(3));
            if ($urandom_range(15) == 0) set_word(18'($urandom));
            v0 = ($urandom_range(3) != 0);
            v1 = ($urandom_range(3) != 0);
            s0 = 18'($urandom);
            s1 = 18'($urandom);
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule